// File: doc/BRIEF.md
# Dual-Port Location Contention Arbiter

This block watches the two ports of a shared dual-port memory. It flags when both ports select the same word at once. When that happens it picks one port to keep access, and it drives an active-low busy to the other port. It also gates each port's write enable to the storage array, so a port that is told it is busy cannot change the array. Read enables pass through unchanged.

A mode input chooses the source of busy. In master mode the block runs its own arbitration and drives busy. In slave mode it takes busy from an external master through per-port inputs and ignores its own comparison. Several devices can then be cascaded to make a wider word, with one master deciding for all of them.

Arbitration is evaluated on clock boundaries. A port "arrives" at a location in the cycle in which its select and address first take their current values. A port that arrived in an earlier cycle wins against a port that arrives now. When both arrive in the same cycle, the left port wins. Once chosen, the winner is stored and kept until the match ends.

Top module: `dp_arbiter`

## Requirements
- R1: A contention exists only when both port selects are high and both addresses are equal. In master mode, with no contention, both busy outputs are high (inactive).
- R2: In master mode, if one port already held its select and address in the previous cycle and the other port arrives at that address now, the earlier port keeps access and the later port's busy goes low in the same cycle. Arrival may come from a select rising or from an address change.
- R3: In master mode, if both ports arrive at the same address in the same cycle, the left port wins: right busy is low and left busy is high. Exactly one busy is low during any contention.
- R4: In master mode, while the match persists, the winner recorded when the contention began is kept, so busy never moves to the other side.
- R5: Busy returns high in the same cycle in which the addresses differ or either select goes low.
- R6: With the mode input high (master), the busy outputs come from local arbitration and the busy inputs have no effect.
- R7: With the mode input low (slave), each busy output equals that port's busy input, and the local address comparison has no effect on busy.
- R8: A port's write enable is high only when its select and write strobe are high and its busy output is high. This holds in both modes.
- R9: A port's read enable is high whenever its select is high and its write strobe is low, whatever the state of busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_master | input | 1 | 1 = master (busy computed locally), 0 = slave (busy taken from inputs) |
| lt_sel | input | 1 | Left port select, active high |
| lt_addr | input | AW | Left port word address |
| lt_wr | input | 1 | Left port write strobe, active high |
| lt_busy_in_n | input | 1 | Left busy from an external master, active low, used in slave mode |
| rt_sel | input | 1 | Right port select, active high |
| rt_addr | input | AW | Right port word address |
| rt_wr | input | 1 | Right port write strobe, active high |
| rt_busy_in_n | input | 1 | Right busy from an external master, active low, used in slave mode |
| lt_busy_n | output | 1 | Busy to the left port, active low |
| rt_busy_n | output | 1 | Busy to the right port, active low |
| lt_we | output | 1 | Gated left write enable to the array |
| rt_we | output | 1 | Gated right write enable to the array |
| lt_re | output | 1 | Left read enable to the array |
| rt_re | output | 1 | Right read enable to the array |

## Verification
Two events can fall in the same cycle: the busy decision and a write strobe from the losing port. The bench provokes this by raising both write strobes in the cycle in which both ports arrive at one address. It then checks that only the winner's write enable is high, and that the loser's read enable still passes. A second collision pits a same-cycle tie against a recorded winner. The right port arrives first and the left follows. On the next cycle both ports look settled, so a fresh decision would favour the left port. The check passes only if busy stays on the left port, which shows the stored winner is used.

// File: rtl/dp_arbiter.sv
module dp_arbiter #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_master,
  input  logic          lt_sel,
  input  logic [AW-1:0] lt_addr,
  input  logic          lt_wr,
  input  logic          lt_busy_in_n,
  input  logic          rt_sel,
  input  logic [AW-1:0] rt_addr,
  input  logic          rt_wr,
  input  logic          rt_busy_in_n,
  output logic          lt_busy_n,
  output logic          rt_busy_n,
  output logic          lt_we,
  output logic          rt_we,
  output logic          lt_re,
  output logic          rt_re
);

  logic          lt_sel_q, rt_sel_q;
  logic [AW-1:0] lt_addr_q, rt_addr_q;
  logic          hold_q, win_rt_q;

  logic match, lt_old, rt_old, win_rt;

  assign match  = lt_sel && rt_sel && (lt_addr == rt_addr);
  assign lt_old = lt_sel_q && (lt_addr_q == lt_addr);
  assign rt_old = rt_sel_q && (rt_addr_q == rt_addr);

  // recorded winner while contention persists; otherwise earlier arrival, tie to left
  assign win_rt = hold_q ? win_rt_q : (rt_old && !lt_old);

  assign lt_busy_n = ms_master ? !(match &&  win_rt) : lt_busy_in_n;
  assign rt_busy_n = ms_master ? !(match && !win_rt) : rt_busy_in_n;

  assign lt_we = lt_sel && lt_wr && lt_busy_n;
  assign rt_we = rt_sel && rt_wr && rt_busy_n;
  assign lt_re = lt_sel && !lt_wr;
  assign rt_re = rt_sel && !rt_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lt_sel_q  <= 1'b0;
      rt_sel_q  <= 1'b0;
      lt_addr_q <= '0;
      rt_addr_q <= '0;
      hold_q    <= 1'b0;
      win_rt_q  <= 1'b0;
    end else begin
      lt_sel_q  <= lt_sel;
      rt_sel_q  <= rt_sel;
      lt_addr_q <= lt_addr;
      rt_addr_q <= rt_addr;
      hold_q    <= match;
      win_rt_q  <= win_rt;
    end
  end

endmodule

// File: rtl/dp_arbiter_sva.sv
module dp_arbiter_sva #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ms_master,
  input logic          lt_sel,
  input logic [AW-1:0] lt_addr,
  input logic          lt_wr,
  input logic          lt_busy_in_n,
  input logic          rt_sel,
  input logic [AW-1:0] rt_addr,
  input logic          rt_wr,
  input logic          rt_busy_in_n,
  input logic          lt_busy_n,
  input logic          rt_busy_n,
  input logic          lt_we,
  input logic          rt_we,
  input logic          lt_re,
  input logic          rt_re
);

  logic same;
  logic seen;
  assign same = lt_sel && rt_sel && (lt_addr == rt_addr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  a_r1_idle_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_master && !same) |-> (lt_busy_n && rt_busy_n));

  a_r3_one_loser: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_master && same) |-> ($countones({~lt_busy_n, ~rt_busy_n}) == 1));

  a_r4_winner_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ms_master && $past(ms_master) && same && $past(same))
      |-> (lt_busy_n == $past(lt_busy_n) && rt_busy_n == $past(rt_busy_n)));

  a_r7_slave_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_master |-> (lt_busy_n == lt_busy_in_n && rt_busy_n == rt_busy_in_n));

  a_r8_no_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!lt_busy_n |-> !lt_we) and (!rt_busy_n |-> !rt_we));

  a_r9_read_passes: assert property (@(posedge clk) disable iff (!rst_n)
    ((lt_sel && !lt_wr) |-> lt_re) and ((rt_sel && !rt_wr) |-> rt_re));

endmodule

bind dp_arbiter dp_arbiter_sva #(.AW(AW)) u_sva (.*);

// File: tb/dp_arbiter_tb.sv
`timescale 1ns/1ps
module dp_arbiter_tb;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_master = 1'b1;
  logic lt_sel = 1'b0, rt_sel = 1'b0, lt_wr = 1'b0, rt_wr = 1'b0;
  logic [AW-1:0] lt_addr = '0, rt_addr = '0;
  logic lt_busy_in_n = 1'b1, rt_busy_in_n = 1'b1;
  logic lt_busy_n, rt_busy_n, lt_we, rt_we, lt_re, rt_re;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dp_arbiter #(.AW(AW)) u_dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic ls, input logic [AW-1:0] la, input logic lw,
                       input logic rs, input logic [AW-1:0] ra, input logic rw);
    @(negedge clk);
    lt_sel = ls; lt_addr = la; lt_wr = lw;
    rt_sel = rs; rt_addr = ra; rt_wr = rw;
    #1;
  endtask

  task automatic idle;
    drive(0, '0, 0, 0, '0, 0);
    drive(0, '0, 0, 0, '0, 0);
  endtask

  task automatic t_reset;
    chk("reset lt_busy_n", lt_busy_n, 1'b1);
    chk("reset rt_busy_n", rt_busy_n, 1'b1);
    chk("reset lt_we", lt_we, 1'b0);
    chk("reset rt_we", rt_we, 1'b0);
  endtask

  task automatic t_r1_no_match;
    drive(1, 12'h010, 1, 1, 12'h011, 1);
    chk("R1 diff addr lt_busy_n", lt_busy_n, 1'b1);
    chk("R1 diff addr rt_busy_n", rt_busy_n, 1'b1);
    chk("R8 free write lt_we", lt_we, 1'b1);
    drive(1, 12'h011, 0, 0, 12'h011, 0);
    chk("R1 one select rt_busy_n", rt_busy_n, 1'b1);
    chk("R1 one select lt_busy_n", lt_busy_n, 1'b1);
    idle();
  endtask

  task automatic t_r2_left_first;
    drive(1, 12'h123, 0, 0, 12'h000, 0);
    drive(1, 12'h123, 0, 1, 12'h123, 0);
    chk("R2 left first rt_busy_n", rt_busy_n, 1'b0);
    chk("R2 left first lt_busy_n", lt_busy_n, 1'b1);
    drive(1, 12'h123, 0, 1, 12'h124, 0);
    chk("R5 addr mismatch rt_busy_n", rt_busy_n, 1'b1);
    idle();
  endtask

  task automatic t_r2_addr_move;
    drive(1, 12'h050, 0, 1, 12'h051, 0);
    drive(1, 12'h051, 0, 1, 12'h051, 0);
    chk("R2 addr arrival lt_busy_n", lt_busy_n, 1'b0);
    chk("R2 addr arrival rt_busy_n", rt_busy_n, 1'b1);
    drive(1, 12'h051, 0, 0, 12'h051, 0);
    chk("R5 select drop lt_busy_n", lt_busy_n, 1'b1);
    idle();
  endtask

  task automatic t_r3_tie_write;
    drive(1, 12'hFFE, 1, 1, 12'hFFE, 1);
    chk("R3 tie rt_busy_n", rt_busy_n, 1'b0);
    chk("R3 tie lt_busy_n", lt_busy_n, 1'b1);
    chk("R8 winner lt_we", lt_we, 1'b1);
    chk("R8 loser rt_we", rt_we, 1'b0);
    drive(1, 12'hFFE, 1, 1, 12'hFFE, 0);
    chk("R9 loser read rt_re", rt_re, 1'b1);
    chk("R3 tie held rt_busy_n", rt_busy_n, 1'b0);
    idle();
  endtask

  task automatic t_r4_hold;
    drive(0, 12'h000, 0, 1, 12'h2A2, 1);
    drive(1, 12'h2A2, 1, 1, 12'h2A2, 1);
    chk("R2 right first lt_busy_n", lt_busy_n, 1'b0);
    chk("R8 right first rt_we", rt_we, 1'b1);
    drive(1, 12'h2A2, 1, 1, 12'h2A2, 1);
    chk("R4 held lt_busy_n", lt_busy_n, 1'b0);
    chk("R4 held rt_busy_n", rt_busy_n, 1'b1);
    chk("R8 held lt_we", lt_we, 1'b0);
    drive(1, 12'h2A2, 1, 1, 12'h2A2, 1);
    chk("R4 held again lt_busy_n", lt_busy_n, 1'b0);
    idle();
  endtask

  task automatic t_r6_master_ignores_inputs;
    @(negedge clk); lt_busy_in_n = 1'b0; rt_busy_in_n = 1'b0;
    drive(1, 12'h007, 1, 1, 12'h008, 1);
    chk("R6 master lt_busy_n", lt_busy_n, 1'b1);
    chk("R6 master rt_we", rt_we, 1'b1);
    @(negedge clk); lt_busy_in_n = 1'b1; rt_busy_in_n = 1'b1;
    idle();
  endtask

  task automatic t_r7_slave;
    @(negedge clk); ms_master = 1'b0; lt_busy_in_n = 1'b0; rt_busy_in_n = 1'b1;
    drive(1, 12'h333, 1, 1, 12'h333, 1);
    chk("R7 slave lt_busy_n", lt_busy_n, 1'b0);
    chk("R7 slave rt_busy_n", rt_busy_n, 1'b1);
    chk("R8 slave lt_we", lt_we, 1'b0);
    chk("R7 slave rt_we", rt_we, 1'b1);
    @(negedge clk); lt_busy_in_n = 1'b1; rt_busy_in_n = 1'b0;
    drive(1, 12'h001, 1, 1, 12'h002, 0);
    chk("R7 slave no match rt_busy_n", rt_busy_n, 1'b0);
    chk("R9 slave rt_re", rt_re, 1'b1);
    chk("R8 slave lt_we", lt_we, 1'b1);
    @(negedge clk); ms_master = 1'b1; rt_busy_in_n = 1'b1;
    idle();
  endtask

  initial begin
    fork
      begin
        #1;
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        idle();
        t_r1_no_match();
        t_r2_left_first();
        t_r2_addr_move();
        t_r3_tie_write();
        t_r4_hold();
        t_r6_master_ignores_inputs();
        t_r7_slave();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          checks++;
          failures++;
          $display("FAIL watchdog actual=timeout expected=completion");
        end
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule